// File: doc/BRIEF.md
# Display link bring-up sequencer

This block runs the source-side bring-up of a multi-lane display link. It holds the main link off until software asks for training. It then walks the link through a clock-recovery training pattern, an equalization training pattern and finally normal operation. Only in normal operation may stream data be sent. Every phase change is announced to the sink with one configuration-register write, and the block then waits for that write to be acknowledged. Progress is decided by status flags read back from a sink status register. The sideband controller performs that read and hands back four decoded flags: clock-recovery lock, equalization done, symbol lock and inter-lane alignment.

Lane count and link rate come from the sink capability field, which must already have been read. The block copies them when training is accepted and drives them as the main-link setup for as long as training or normal operation lasts; while the link is off the setup is zero. Status is polled at a gap programmed by software. Five failed polls in either training phase abort training and raise a failure flag. A lost flag during normal operation stops the stream and restarts training from clock recovery.

Top module: `link_bringup_ctrl`

## Requirements
- R1: After synchronous reset, pat_sel is 0, and wr_req, rd_req, link_up, stream_en and train_fail are all 0. lane_cfg and rate_cfg are 0.
- R2: Training is accepted only while the link is off, and only when start_req and cap_valid are both high. A start_req without cap_valid starts no write. On acceptance cap_lanes and cap_rate are captured onto lane_cfg and rate_cfg, and later changes of those inputs have no effect until the next accepted start.
- R3: Entering clock recovery raises wr_req to address PAT_ADDR (default 0x00102) with wr_data = 1, and sets pat_sel = 1 (pattern encoding: 0 none, 1 clock-recovery, 2 equalization; 3 never appears). wr_req stays high until a cycle with wr_ack.
- R4: After each accepted write, and after each status read that keeps the phase, rd_req to address STAT_ADDR (default 0x00202) rises exactly poll_gap+1 cycles later. rd_req stays high until a cycle with rd_done.
- R5: In clock recovery, a status read with cr_lock high moves to equalization: a write of wr_data = 2 and pat_sel = 2.
- R6: In equalization, a read with any of the four flags low keeps the phase and schedules another poll. A read with all four high enters normal operation.
- R7: Entering normal operation writes wr_data = 0 with pat_sel = 0 and raises link_up. stream_en stays low until that write is acknowledged and is high from the next cycle on.
- R8: The fifth failed status read in one training phase (clock recovery or equalization) turns the link off: pat_sel = 0, link_up = 0, lane_cfg = 0, and train_fail = 1. Four failed reads do not.
- R9: In normal operation, a status read with any of the four flags low drops stream_en and link_up at once and restarts from clock recovery with a wr_data = 1 write.
- R10: train_fail holds until the next accepted start, which clears it.
- R11: wr_req and rd_req are never high together, and stream_en is high only with link_up high and pat_sel = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to begin training |
| cap_valid | input | 1 | Capability field has been read and cap_lanes/cap_rate are valid |
| cap_lanes | input | LANE_W | Lane count from the capability field |
| cap_rate | input | RATE_W | Link rate code from the capability field |
| poll_gap | input | GAP_W | Idle cycles minus one between a handshake and the next status read |
| wr_ack | input | 1 | Sideband write acknowledge |
| rd_done | input | 1 | Sideband read complete; status flags valid |
| sts_cr_lock | input | 1 | Clock-recovery lock flag from the status read |
| sts_eq_done | input | 1 | Equalization-done flag from the status read |
| sts_sym_lock | input | 1 | Symbol-lock flag from the status read |
| sts_align | input | 1 | Inter-lane alignment flag from the status read |
| pat_sel | output | 2 | Training pattern on the main link: 0 none, 1 clock recovery, 2 equalization |
| wr_req | output | 1 | Sideband register write request |
| wr_addr | output | ADDR_W | Write address (pattern-announce register) |
| wr_data | output | DATA_W | Write data; the low two bits carry the pattern code |
| rd_req | output | 1 | Sideband status read request |
| rd_addr | output | ADDR_W | Read address (status register) |
| lane_cfg | output | LANE_W | Main-link lane setup; 0 while the link is off |
| rate_cfg | output | RATE_W | Main-link rate setup; 0 while the link is off |
| link_up | output | 1 | Normal operation has been entered |
| stream_en | output | 1 | Stream data may be sent |
| train_fail | output | 1 | Last training attempt aborted |

## Verification
The hardest states to reach are the failure and loss paths. One is the fifth consecutive failed poll inside a phase, right after four failures that must not abort. The other is a single flag dropping once normal operation is reached. The bench gets there with handshake tasks that answer every write and every read. Each training run uses its own poll gap and its own series of flag words. Across the runs these words cover every partial equalization combination, a drop of each of the four flags in normal operation, and a five-failure abort in each training phase.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef enum logic [3:0] {
    S_OFF,
    S_CR_ANN,  S_CR_GAP,  S_CR_POLL,
    S_EQ_ANN,  S_EQ_GAP,  S_EQ_POLL,
    S_RUN_ANN, S_RUN_GAP, S_RUN_POLL
  } lbc_state_e;

  localparam logic [1:0] PAT_NONE = 2'd0;
  localparam logic [1:0] PAT_CLK  = 2'd1;
  localparam logic [1:0] PAT_EQL  = 2'd2;

  function automatic logic [1:0] pat_of(lbc_state_e s);
    case (s)
      S_CR_ANN, S_CR_GAP, S_CR_POLL: pat_of = PAT_CLK;
      S_EQ_ANN, S_EQ_GAP, S_EQ_POLL: pat_of = PAT_EQL;
      default:                       pat_of = PAT_NONE;
    endcase
  endfunction

  function automatic logic is_ann(lbc_state_e s);
    is_ann = (s == S_CR_ANN) || (s == S_EQ_ANN) || (s == S_RUN_ANN);
  endfunction

  function automatic logic is_poll(lbc_state_e s);
    is_poll = (s == S_CR_POLL) || (s == S_EQ_POLL) || (s == S_RUN_POLL);
  endfunction

endpackage

// File: rtl/lbc_gap_timer.sv
module lbc_gap_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] gap,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= gap;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0) && !load;
endmodule

// File: rtl/lbc_retry_ctr.sv
module lbc_retry_ctr #(
  parameter int MAX = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int CW = $clog2(MAX + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (bump)    cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(MAX - 1));
endmodule

// File: rtl/lbc_seq.sv
module lbc_seq
  import lbc_pkg::*;
#(
  parameter int LANE_W = 3,
  parameter int RATE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              cap_valid,
  input  logic [LANE_W-1:0] cap_lanes,
  input  logic [RATE_W-1:0] cap_rate,
  input  logic              wr_ack,
  input  logic              rd_done,
  input  logic [3:0]        flags,
  input  logic              tmr_expired,
  input  logic              rty_last,
  output logic              tmr_load,
  output logic              rty_clear,
  output logic              rty_bump,
  output logic [1:0]        pat_sel,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [LANE_W-1:0] lane_cfg,
  output logic [RATE_W-1:0] rate_cfg,
  output logic              link_up,
  output logic              stream_en,
  output logic              train_fail
);
  lbc_state_e state, nxt;
  logic latch, fail_set, fail_clr;
  logic all_ok, cr_ok;
  logic [LANE_W-1:0] lanes_q;
  logic [RATE_W-1:0] rate_q;

  assign cr_ok  = flags[0];
  assign all_ok = &flags;

  always_comb begin
    nxt       = state;
    tmr_load  = 1'b0;
    rty_clear = 1'b0;
    rty_bump  = 1'b0;
    latch     = 1'b0;
    fail_set  = 1'b0;
    fail_clr  = 1'b0;
    case (state)
      S_OFF: if (start_req && cap_valid) begin
        nxt = S_CR_ANN; latch = 1'b1; fail_clr = 1'b1; rty_clear = 1'b1;
      end
      S_CR_ANN:  if (wr_ack) begin nxt = S_CR_GAP; tmr_load = 1'b1; end
      S_CR_GAP:  if (tmr_expired) nxt = S_CR_POLL;
      S_CR_POLL: if (rd_done) begin
        if (cr_ok) begin
          nxt = S_EQ_ANN; rty_clear = 1'b1;
        end else if (rty_last) begin
          nxt = S_OFF; fail_set = 1'b1;
        end else begin
          nxt = S_CR_GAP; tmr_load = 1'b1; rty_bump = 1'b1;
        end
      end
      S_EQ_ANN:  if (wr_ack) begin nxt = S_EQ_GAP; tmr_load = 1'b1; end
      S_EQ_GAP:  if (tmr_expired) nxt = S_EQ_POLL;
      S_EQ_POLL: if (rd_done) begin
        if (all_ok) begin
          nxt = S_RUN_ANN;
        end else if (rty_last) begin
          nxt = S_OFF; fail_set = 1'b1;
        end else begin
          nxt = S_EQ_GAP; tmr_load = 1'b1; rty_bump = 1'b1;
        end
      end
      S_RUN_ANN:  if (wr_ack) begin nxt = S_RUN_GAP; tmr_load = 1'b1; end
      S_RUN_GAP:  if (tmr_expired) nxt = S_RUN_POLL;
      S_RUN_POLL: if (rd_done) begin
        if (all_ok) begin
          nxt = S_RUN_GAP; tmr_load = 1'b1;
        end else begin
          nxt = S_CR_ANN; rty_clear = 1'b1;
        end
      end
      default: nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_OFF;
      lanes_q    <= '0;
      rate_q     <= '0;
      pat_sel    <= PAT_NONE;
      wr_req     <= 1'b0;
      wr_data    <= '0;
      rd_req     <= 1'b0;
      lane_cfg   <= '0;
      rate_cfg   <= '0;
      link_up    <= 1'b0;
      stream_en  <= 1'b0;
      train_fail <= 1'b0;
    end else begin
      state   <= nxt;
      if (latch) begin
        lanes_q <= cap_lanes;
        rate_q  <= cap_rate;
      end
      pat_sel   <= pat_of(nxt);
      wr_req    <= is_ann(nxt);
      wr_data   <= {{(DATA_W-2){1'b0}}, pat_of(nxt)};
      rd_req    <= is_poll(nxt);
      lane_cfg  <= (nxt == S_OFF) ? '0 : (latch ? cap_lanes : lanes_q);
      rate_cfg  <= (nxt == S_OFF) ? '0 : (latch ? cap_rate  : rate_q);
      link_up   <= (nxt == S_RUN_ANN) || (nxt == S_RUN_GAP) || (nxt == S_RUN_POLL);
      stream_en <= (nxt == S_RUN_GAP) || (nxt == S_RUN_POLL);
      if (fail_set)      train_fail <= 1'b1;
      else if (fail_clr) train_fail <= 1'b0;
    end
  end
endmodule

// File: rtl/link_bringup_ctrl.sv
module link_bringup_ctrl #(
  parameter int              LANE_W    = 3,
  parameter int              RATE_W    = 8,
  parameter int              GAP_W     = 16,
  parameter int              ADDR_W    = 20,
  parameter int              DATA_W    = 8,
  parameter int              MAX_POLLS = 5,
  parameter logic [ADDR_W-1:0] PAT_ADDR  = 20'h00102,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 20'h00202
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              cap_valid,
  input  logic [LANE_W-1:0] cap_lanes,
  input  logic [RATE_W-1:0] cap_rate,
  input  logic [GAP_W-1:0]  poll_gap,
  input  logic              wr_ack,
  input  logic              rd_done,
  input  logic              sts_cr_lock,
  input  logic              sts_eq_done,
  input  logic              sts_sym_lock,
  input  logic              sts_align,
  output logic [1:0]        pat_sel,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LANE_W-1:0] lane_cfg,
  output logic [RATE_W-1:0] rate_cfg,
  output logic              link_up,
  output logic              stream_en,
  output logic              train_fail
);
  logic       tmr_load, tmr_expired;
  logic       rty_clear, rty_bump, rty_last;
  logic [3:0] flags;

  assign flags   = {sts_align, sts_sym_lock, sts_eq_done, sts_cr_lock};
  assign wr_addr = PAT_ADDR;
  assign rd_addr = STAT_ADDR;

  lbc_gap_timer #(.W(GAP_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .gap(poll_gap), .expired(tmr_expired)
  );

  lbc_retry_ctr #(.MAX(MAX_POLLS)) u_retry (
    .clk(clk), .rst(rst), .clear(rty_clear), .bump(rty_bump), .last(rty_last)
  );

  lbc_seq #(.LANE_W(LANE_W), .RATE_W(RATE_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .cap_valid(cap_valid),
    .cap_lanes(cap_lanes), .cap_rate(cap_rate), .wr_ack(wr_ack), .rd_done(rd_done),
    .flags(flags), .tmr_expired(tmr_expired), .rty_last(rty_last),
    .tmr_load(tmr_load), .rty_clear(rty_clear), .rty_bump(rty_bump),
    .pat_sel(pat_sel), .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
    .lane_cfg(lane_cfg), .rate_cfg(rate_cfg), .link_up(link_up),
    .stream_en(stream_en), .train_fail(train_fail)
  );
endmodule

// File: rtl/lbc_chk.sv
module lbc_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_req,
  input logic       wr_ack,
  input logic       rd_req,
  input logic       rd_done,
  input logic [1:0] pat_sel,
  input logic       link_up,
  input logic       stream_en,
  input logic       train_fail
);
  assert_excl_req_R11: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && rd_req));

  assert_stream_gate_R11: assert property (@(posedge clk) disable iff (rst)
    stream_en |-> (link_up && pat_sel == 2'd0));

  assert_pat_legal_R3: assert property (@(posedge clk) disable iff (rst)
    pat_sel != 2'd3);

  assert_wr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> wr_req);

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_done) |=> rd_req);

  assert_stream_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(stream_en) |-> $past(wr_ack));

  assert_fail_is_off_R8: assert property (@(posedge clk) disable iff (rst)
    train_fail |-> (!link_up && pat_sel == 2'd0 && !wr_req && !rd_req));
endmodule

bind link_bringup_ctrl lbc_chk u_chk (
  .clk(clk), .rst(rst), .wr_req(wr_req), .wr_ack(wr_ack), .rd_req(rd_req),
  .rd_done(rd_done), .pat_sel(pat_sel), .link_up(link_up),
  .stream_en(stream_en), .train_fail(train_fail)
);

// File: tb/link_bringup_ctrl_tb.sv
module link_bringup_ctrl_tb;
  localparam logic [19:0] PAT_A  = 20'h00102;
  localparam logic [19:0] STAT_A = 20'h00202;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 0, cap_valid = 0, wr_ack = 0, rd_done = 0;
  logic [2:0]  cap_lanes = 0;
  logic [7:0]  cap_rate = 0;
  logic [15:0] poll_gap = 0;
  logic [3:0]  fl = 0;
  logic [1:0]  pat_sel;
  logic        wr_req, rd_req, link_up, stream_en, train_fail;
  logic [19:0] wr_addr, rd_addr;
  logic [7:0]  wr_data, rate_cfg;
  logic [2:0]  lane_cfg;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  link_bringup_ctrl u_dut (
    .clk(clk), .rst(rst), .start_req(start_req), .cap_valid(cap_valid),
    .cap_lanes(cap_lanes), .cap_rate(cap_rate), .poll_gap(poll_gap),
    .wr_ack(wr_ack), .rd_done(rd_done),
    .sts_cr_lock(fl[0]), .sts_eq_done(fl[1]), .sts_sym_lock(fl[2]), .sts_align(fl[3]),
    .pat_sel(pat_sel), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .lane_cfg(lane_cfg), .rate_cfg(rate_cfg),
    .link_up(link_up), .stream_en(stream_en), .train_fail(train_fail)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_wr(input int exp, input string tag);
    int n = 0;
    while (!wr_req && n < 2000) begin @(negedge clk); n++; end
    chk(wr_req, {tag, " write request"}, wr_req, 1);
    chk(wr_data == exp[7:0], {tag, " write data"}, wr_data, exp);
    chk(pat_sel == exp[1:0], {tag, " pattern select"}, pat_sel, exp);
    chk(wr_addr == PAT_A, {tag, " write address"}, wr_addr, PAT_A);
  endtask

  task automatic ack_wr();
    wr_ack = 1; @(negedge clk); wr_ack = 0;
  endtask

  task automatic serve_rd(input logic [3:0] f, input string tag);
    int n = 0;
    while (!rd_req && n < 2000) begin @(negedge clk); n++; end
    chk(n == int'(poll_gap) + 1, {tag, " R4 poll spacing"}, n, int'(poll_gap) + 1);
    chk(rd_addr == STAT_A, "R4 read address", rd_addr, STAT_A);
    fl = f; rd_done = 1; @(negedge clk); rd_done = 0; fl = 4'b0000;
  endtask

  task automatic do_start(input logic [2:0] ln, input logic [7:0] rt);
    start_req = 1; cap_valid = 1; cap_lanes = ln; cap_rate = rt;
    @(negedge clk);
    start_req = 0; cap_valid = 0; cap_lanes = ~ln; cap_rate = ~rt;
    chk(train_fail == 0, "R10 fail cleared by start", train_fail, 0);
    chk(lane_cfg == ln, "R2 lane setup captured", lane_cfg, ln);
    chk(rate_cfg == rt, "R2 rate setup captured", rate_cfg, rt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gaps [4] = '{0, 1, 3, 7};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(pat_sel == 0, "R1 pat_sel", pat_sel, 0);
    chk(!wr_req && !rd_req, "R1 requests", {wr_req, rd_req}, 0);
    chk(!link_up && !stream_en && !train_fail, "R1 flags", {link_up, stream_en, train_fail}, 0);
    chk(lane_cfg == 0 && rate_cfg == 0, "R1 link setup", lane_cfg, 0);

    // R2 start without capability is ignored
    start_req = 1; @(negedge clk); start_req = 0;
    repeat (4) @(negedge clk);
    chk(!wr_req, "R2 start without capability", wr_req, 0);
    chk(pat_sel == 0 && lane_cfg == 0, "R2 link stays off", pat_sel, 0);

    for (int i = 0; i < 4; i++) begin
      logic [2:0] ln = 3'(1 << (i % 3));
      logic [7:0] rt = 8'(8'h06 + 8'(i * 4));
      poll_gap = 16'(gaps[i]);
      do_start(ln, rt);
      wait_wr(1, "R3 clock-recovery entry");
      ack_wr();
      chk(!wr_req && pat_sel == 1, "R3 request drops after ack", wr_req, 0);
      // i failed clock-recovery polls, then lock
      for (int k = 0; k < i; k++) serve_rd(4'b1110, "R5 no lock");
      serve_rd(4'b0001, "R5 lock");
      wait_wr(2, "R5 equalization entry");
      chk(rate_cfg == rt, "R2 rate unaffected by input change", rate_cfg, rt);
      ack_wr();
      // partial equalization words, at most four per phase
      for (int c = 4 * i; c < 4 * i + 4 && c < 15; c++) begin
        serve_rd(4'(c), "R6 partial flags");
        chk(!wr_req && pat_sel == 2, "R6 stays in equalization", pat_sel, 2);
      end
      serve_rd(4'b1111, "R6 all flags");
      wait_wr(0, "R7 normal entry");
      chk(link_up && !stream_en, "R7 stream waits for ack", {link_up, stream_en}, 2);
      ack_wr();
      chk(stream_en && link_up, "R7 stream enabled", stream_en, 1);
      serve_rd(4'b1111, "R7 normal poll");
      serve_rd(4'b1111, "R7 normal poll");
      chk(stream_en && pat_sel == 0, "R11 stream with pattern none", stream_en, 1);
      serve_rd(4'b1111 & ~4'(1 << i), "R9 flag loss");
      chk(!stream_en && !link_up, "R9 stream dropped", stream_en, 0);
      wait_wr(1, "R9 retrain from clock recovery");
      ack_wr();
      if (i % 2 == 0) begin
        for (int k = 0; k < 4; k++) serve_rd(4'b0000, "R8 cr failures");
        chk(!train_fail && pat_sel == 1, "R8 four failures keep phase", pat_sel, 1);
        serve_rd(4'b1110, "R8 fifth cr failure");
      end else begin
        serve_rd(4'b0001, "R8 lock");
        wait_wr(2, "R8 equalization entry");
        ack_wr();
        for (int k = 0; k < 4; k++) serve_rd(4'b0111, "R8 eq failures");
        chk(!train_fail && pat_sel == 2, "R8 four failures keep phase", pat_sel, 2);
        serve_rd(4'b1011, "R8 fifth eq failure");
      end
      chk(train_fail, "R8 fail raised", train_fail, 1);
      chk(pat_sel == 0 && !link_up && lane_cfg == 0, "R8 link off", pat_sel, 0);
      repeat (3) @(negedge clk);
      chk(train_fail && !wr_req, "R10 fail held", train_fail, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule